// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block works out which of five UART interrupt causes is pending and reports the most urgent one as an identification byte. It also drives an interrupt request line. The five causes are receiver line errors, received data reaching a threshold, receive timeout, transmit holding register empty and modem status change. The FIFOs, shift registers and bus interface sit outside the block. They reach it as plain level inputs and one-cycle strobes: the receive fill level, a push pulse, a character-time tick, an error pulse, modem delta pulses, the transmit-empty level, and the register read and write strobes.

The enable register and the receive threshold code are held inside the block and loaded by their write strobes. Line-error, modem and transmit-empty events are latched as pending flags whether or not their enable is set. The enable only decides whether a flag may be reported. The identification byte and the request line are registered, so they follow a change of any pending cause by one clock.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset the identification byte is 8'hC1, the request line is 0, and all enables are 0.
- R2: The upper nibble of the identification byte is always 4'b1100. Bit 0 is 0 when a cause is reported and 1 when none is reported. The request line is the inverse of bit 0.
- R3: A line-error pulse latches a line-status cause. When enable bit 2 is set, that cause is reported with bits 3:1 = 3'b011 (byte 8'hC6). A line-status read clears it.
- R4: Received-data-available is reported with bits 3:1 = 3'b010 (byte 8'hC4) while the fill level is at or above the threshold and enable bit 0 is set. Threshold code 2'b00 selects 1 byte, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14. The cause drops as soon as the level falls below the threshold.
- R5: When the fill level has been nonzero for four character ticks with no push and no pop, a timeout is reported with bits 3:1 = 3'b110 (byte 8'hCC), under enable bit 0. A push or a pop restarts the count, and an empty FIFO clears it.
- R6: A rising edge of transmit-empty latches a holding-empty cause. When enable bit 1 is set, that cause is reported with bits 3:1 = 3'b001 (byte 8'hC2). A holding-register write clears it. An identification read clears it only while it is the reported cause.
- R7: Any modem delta pulse latches a modem cause. When enable bit 3 is set, that cause is reported with bits 3:1 = 3'b000 (byte 8'hC0). A modem-status read clears it.
- R8: When several causes are enabled and pending, the one reported is chosen in this order: line status, then received data, then timeout, then holding empty, then modem.
- R9: A disabled cause is never reported but stays latched. It is reported once its enable bit is set.
- R10: An identification read while a higher cause is reported leaves a pending holding-empty cause latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable bits: 0 data/timeout, 1 holding empty, 2 line status, 3 modem |
| fcr_wr | input | 1 | Threshold code write strobe |
| fcr_trig | input | 2 | Receive threshold code |
| thr_wr | input | 1 | Holding register write strobe |
| rbr_rd | input | 1 | Receive buffer read (FIFO pop) strobe |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| ls_err | input | 1 | Line error event pulse |
| msr_delta | input | 4 | Modem delta event pulses |
| tx_empty | input | 1 | Transmit holding empty level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO push pulse |
| char_tick | input | 1 | One pulse per character time |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Each cause is first raised on its own. This shows that its code and its clearing strobe are distinct from those of every other cause. Each receive threshold code is tried one byte below and exactly at its threshold, which separates the four levels from each other. Timeout runs show the fourth tick firing and a push or pop restarting the count. Stacked causes are then removed one at a time from the top, which exposes the whole priority order. Runs with enables cleared, and an identification read under a higher cause, tell masking apart from clearing.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_THRE  = 3'b001,
    ID_RDA   = 3'b010,
    ID_LINE  = 3'b011,
    ID_TOUT  = 3'b110
  } irq_id_e;

  localparam logic [3:0] IIR_TOP = 4'b1100;

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_bytes = 1;
      2'b01:   trig_bytes = 4;
      2'b10:   trig_bytes = 8;
      default: trig_bytes = 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (SET_WINS)
      q <= set | (q & ~clr);
    else
      q <= ~clr & (set | q);
  end
endmodule

// File: rtl/uart_irq_tout.sv
module uart_irq_tout #(
  parameter int LVL_W      = 5,
  parameter int TOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             hit
);
  localparam int CW = $clog2(TOUT_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TOUT_CHARS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || rx_level == '0 || rx_push || rx_pop)
      cnt <= '0;
    else if (char_tick && cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == LIMIT);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [3:0] en,
  input  logic       line_p,
  input  logic       rda_p,
  input  logic       tout_p,
  input  logic       thre_p,
  input  logic       modem_p,
  output irq_id_e    id,
  output logic       any
);
  always_comb begin
    any = 1'b1;
    id  = ID_MODEM;
    if (en[2] && line_p)
      id = ID_LINE;
    else if (en[0] && rda_p)
      id = ID_RDA;
    else if (en[0] && tout_p)
      id = ID_TOUT;
    else if (en[1] && thre_p)
      id = ID_THRE;
    else if (en[3] && modem_p)
      id = ID_MODEM;
    else
      any = 1'b0;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W      = 5,
  parameter int TOUT_CHARS = 4,
  parameter int DELTA_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ier_wr,
  input  logic [3:0]         ier_wdata,
  input  logic               fcr_wr,
  input  logic [1:0]         fcr_trig,
  input  logic               thr_wr,
  input  logic               rbr_rd,
  input  logic               iir_rd,
  input  logic               lsr_rd,
  input  logic               msr_rd,
  input  logic               ls_err,
  input  logic [DELTA_W-1:0] msr_delta,
  input  logic               tx_empty,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               rx_push,
  input  logic               char_tick,
  output logic [7:0]         iir_o,
  output logic               irq_o
);
  logic [3:0] ier_q;
  logic [1:0] trig_q;
  logic       tx_empty_d;
  logic       line_p, modem_p, thre_p, tout_p, rda_p;
  logic       thre_ack;
  logic       any;
  irq_id_e    id;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q      <= '0;
      trig_q     <= '0;
      tx_empty_d <= 1'b0;
    end else begin
      if (ier_wr) ier_q  <= ier_wdata;
      if (fcr_wr) trig_q <= fcr_trig;
      tx_empty_d <= tx_empty;
    end
  end

  assign thre_ack = iir_rd & ~iir_o[0] & (iir_o[3:1] == ID_THRE);
  assign rda_p    = int'(rx_level) >= int'(trig_bytes(trig_q));

  uart_irq_flag #(.SET_WINS(1'b1)) u_line (
    .clk(clk), .rst(rst), .set(ls_err), .clr(lsr_rd), .q(line_p));

  uart_irq_flag #(.SET_WINS(1'b1)) u_modem (
    .clk(clk), .rst(rst), .set(|msr_delta), .clr(msr_rd), .q(modem_p));

  uart_irq_flag #(.SET_WINS(1'b0)) u_thre (
    .clk(clk), .rst(rst), .set(tx_empty & ~tx_empty_d),
    .clr(thr_wr | thre_ack), .q(thre_p));

  uart_irq_tout #(.LVL_W(LVL_W), .TOUT_CHARS(TOUT_CHARS)) u_tout (
    .clk(clk), .rst(rst), .rx_level(rx_level), .rx_push(rx_push),
    .rx_pop(rbr_rd), .char_tick(char_tick), .hit(tout_p));

  uart_irq_prio u_prio (
    .en(ier_q), .line_p(line_p), .rda_p(rda_p), .tout_p(tout_p),
    .thre_p(thre_p), .modem_p(modem_p), .id(id), .any(any));

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= {IIR_TOP, 3'b000, 1'b1};
      irq_o <= 1'b0;
    end else begin
      iir_o <= {IIR_TOP, id, ~any};
      irq_o <= any;
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       iir_o,
  input logic             irq_o,
  input logic [3:0]       ier_q,
  input logic             line_p,
  input logic             modem_p,
  input logic             thre_p,
  input logic             tout_p,
  input logic             ls_err,
  input logic             lsr_rd,
  input logic             msr_rd,
  input logic             thr_wr,
  input logic             any_delta,
  input logic [LVL_W-1:0] rx_level
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk) $past(rst) |-> (iir_o == 8'hC1 && !irq_o));
  // R2
  a_r2_irq_inverse: assert property (@(posedge clk) disable iff (rst) irq_o == !iir_o[0]);
  a_r2_top_nibble: assert property (@(posedge clk) disable iff (rst) iir_o[7:4] == 4'b1100);
  // R3
  a_r3_line_clear: assert property (@(posedge clk) disable iff (rst) (lsr_rd && !ls_err) |=> !line_p);
  // R7
  a_r7_modem_clear: assert property (@(posedge clk) disable iff (rst) (msr_rd && !any_delta) |=> !modem_p);
  // R6
  a_r6_thr_write_clear: assert property (@(posedge clk) disable iff (rst) thr_wr |=> !thre_p);
  // R5
  a_r5_empty_no_tout: assert property (@(posedge clk) disable iff (rst) (rx_level == '0) |=> !tout_p);
  // R8
  a_r8_line_first: assert property (@(posedge clk) disable iff (rst) (line_p && ier_q[2]) |=> iir_o[3:0] == 4'b0110);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) chk (
  .clk(clk), .rst(rst), .iir_o(iir_o), .irq_o(irq_o), .ier_q(ier_q),
  .line_p(line_p), .modem_p(modem_p), .thre_p(thre_p), .tout_p(tout_p),
  .ls_err(ls_err), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
  .any_delta(|msr_delta), .rx_level(rx_level));

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ier_wr = 0, fcr_wr = 0, thr_wr = 0, rbr_rd = 0, iir_rd = 0;
  logic       lsr_rd = 0, msr_rd = 0, ls_err = 0, tx_empty = 0, rx_push = 0, char_tick = 0;
  logic [3:0] ier_wdata = 0, msr_delta = 0;
  logic [1:0] fcr_trig = 0;
  logic [4:0] rx_level = 0;
  logic [7:0] iir_o;
  logic       irq_o;

  always #2.5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .fcr_wr(fcr_wr), .fcr_trig(fcr_trig), .thr_wr(thr_wr), .rbr_rd(rbr_rd),
    .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .ls_err(ls_err),
    .msr_delta(msr_delta), .tx_empty(tx_empty), .rx_level(rx_level),
    .rx_push(rx_push), .char_tick(char_tick), .iir_o(iir_o), .irq_o(irq_o));

  typedef struct {
    logic [7:0] iir;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_iir(input logic [7:0] v, input string tag);
    exp_t e;
    run(2);
    e.iir = v;
    e.tag = tag;
    q.push_back(e);
    run(1);
  endtask

  task automatic set_ier(input logic [3:0] v);
    ier_wdata = v; ier_wr = 1; run(1); ier_wr = 0;
  endtask

  task automatic set_trig(input logic [1:0] v);
    fcr_trig = v; fcr_wr = 1; run(1); fcr_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1; run(1); char_tick = 0; run(1);
    end
  endtask

  task automatic strobe_ls;   ls_err = 1; run(1); ls_err = 0; endtask
  task automatic strobe_lsr;  lsr_rd = 1; run(1); lsr_rd = 0; endtask
  task automatic strobe_msr;  msr_rd = 1; run(1); msr_rd = 0; endtask
  task automatic strobe_iir;  iir_rd = 1; run(1); iir_rd = 0; endtask
  task automatic strobe_thr;  thr_wr = 1; run(1); thr_wr = 0; endtask
  task automatic strobe_pop;  rbr_rd = 1; run(1); rbr_rd = 0; endtask
  task automatic strobe_push; rx_push = 1; run(1); rx_push = 0; endtask
  task automatic strobe_delta(input logic [3:0] d);
    msr_delta = d; run(1); msr_delta = 0;
  endtask
  task automatic thre_rise;
    tx_empty = 0; run(2); tx_empty = 1; run(1);
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (iir_o !== e.iir || irq_o !== ~e.iir[0]) begin
          n_fail++;
          $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                   e.tag, iir_o, irq_o, e.iir, ~e.iir[0]);
        end
      end
    end
  end

  initial begin
    run(3);
    rst = 0;
    expect_iir(8'hC1, "R1 reset value");

    // causes latched while all enables are 0
    strobe_ls();
    strobe_delta(4'b0100);
    expect_iir(8'hC1, "R1 R9 nothing reported with enables 0");
    set_ier(4'hF);
    expect_iir(8'hC6, "R3 R8 line status over modem");
    strobe_lsr();
    expect_iir(8'hC0, "R3 line clear exposes R7 modem");
    strobe_msr();
    expect_iir(8'hC1, "R7 modem cleared, R2 none pending");

    // thresholds
    set_trig(2'b01); rx_level = 3;
    expect_iir(8'hC1, "R4 code 01 level 3 below");
    rx_level = 4;
    expect_iir(8'hC4, "R4 code 01 level 4 at");
    rx_level = 3;
    expect_iir(8'hC1, "R4 drops below threshold");
    set_trig(2'b11); rx_level = 13;
    expect_iir(8'hC1, "R4 code 11 level 13 below");
    rx_level = 14;
    expect_iir(8'hC4, "R4 code 11 level 14 at");
    set_trig(2'b10); rx_level = 7;
    expect_iir(8'hC1, "R4 code 10 level 7 below");
    rx_level = 8;
    expect_iir(8'hC4, "R4 code 10 level 8 at");
    set_trig(2'b00); rx_level = 1;
    expect_iir(8'hC4, "R4 code 00 level 1 at");
    rx_level = 0;
    expect_iir(8'hC1, "R4 code 00 level 0 below");

    // timeout
    set_trig(2'b01); rx_level = 2;
    ticks(3);
    expect_iir(8'hC1, "R5 three ticks no timeout");
    ticks(1);
    expect_iir(8'hCC, "R5 fourth tick timeout");
    strobe_pop();
    expect_iir(8'hC1, "R5 pop clears timeout");
    ticks(3); strobe_push(); ticks(1);
    expect_iir(8'hC1, "R5 push restarts count");
    ticks(3);
    expect_iir(8'hCC, "R5 timeout after restart");
    rx_level = 0;
    expect_iir(8'hC1, "R5 empty clears timeout");

    // holding empty
    thre_rise();
    expect_iir(8'hC2, "R6 holding empty reported");
    strobe_iir();
    expect_iir(8'hC1, "R6 IIR read clears");
    thre_rise();
    expect_iir(8'hC2, "R6 holding empty again");
    strobe_thr();
    expect_iir(8'hC1, "R6 THR write clears");

    // IIR read under a higher cause
    thre_rise();
    strobe_ls();
    expect_iir(8'hC6, "R10 line status above holding empty");
    strobe_iir();
    expect_iir(8'hC6, "R10 still line status after IIR read");
    strobe_lsr();
    expect_iir(8'hC2, "R10 holding empty kept");
    strobe_thr();
    expect_iir(8'hC1, "R10 cleared by THR write");

    // full priority stack
    strobe_delta(4'b0001);
    thre_rise();
    rx_level = 2;
    ticks(4);
    expect_iir(8'hCC, "R8 timeout over holding empty and modem");
    rx_level = 4;
    expect_iir(8'hC4, "R8 data available over timeout");
    strobe_ls();
    expect_iir(8'hC6, "R8 line status over all");
    strobe_lsr();
    expect_iir(8'hC4, "R8 back to data available");
    rx_level = 0;
    expect_iir(8'hC2, "R8 holding empty next");
    strobe_thr();
    expect_iir(8'hC0, "R8 modem last");
    strobe_msr();
    expect_iir(8'hC1, "R8 all cleared");

    // masking
    set_ier(4'h1);
    strobe_delta(4'b1000);
    expect_iir(8'hC1, "R9 modem masked");
    set_ier(4'h9);
    expect_iir(8'hC0, "R9 modem reported once enabled");
    strobe_msr();
    expect_iir(8'hC1, "R7 modem read clears");

    run(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    run(20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule